// File: doc/BRIEF.md
# Battery Cycle Fail-Safe Supervisor

This block watches over one battery charge or discharge cycle. Four comparator outputs come in as asynchronous fault flags: cell voltage above its programmed maximum, cell voltage below the fixed 900 mV end-of-discharge level, and thermistor readings that mean too hot or too cold. The block resynchronizes these flags and shows them in a status word. It also runs a cycle timer whose limit comes from a 3-bit command field.

When a fault that belongs to the current mode appears, the block sets a sticky fail-safe flag and raises a halt output, and the active cycle stops. The charge mode counts an over-voltage as a fault. The discharge mode counts an end-of-discharge voltage as a fault. Both modes count the two temperature faults and the timeout. The fail-safe flag stays set until a clear command removes it.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `bat_failsafe_sup`

## Requirements
- R1: Status bits [6:3] are, in that order from high to low, the cold, hot, end-of-discharge and over-voltage flags. Each bit equals its raw input two clock edges after the input changes. Status bits [2:0] always read 0.
- R2: For a timeout code c from 1 to 7, the limit is BASE_TICKS<<(c-1) ticks, and one tick occurs every PRESCALE running cycles. Status bit 7 rises on exactly the PRESCALE*limit-th clock edge after the edge that sampled the start pulse, provided the cycle runs without a stop.
- R3: Timeout code 0 disables the timeout, so status bit 7 never sets.
- R4: A start pulse clears the timer, the prescaler and status bit 7 on the following edge.
- R5: The timer saturates at its limit. Status bit 7 stays set until the next start pulse.
- R6: In charge mode (mode 01), an over-voltage, hot, cold or timeout condition sets status bit 8 (fail-safe) one edge after it shows in the status word. The end-of-discharge flag has no effect on bit 8 in this mode.
- R7: In discharge mode (mode 10), an end-of-discharge, hot, cold or timeout condition sets bit 8. The over-voltage flag has no effect on bit 8 in this mode.
- R8: In idle mode (mode 00 or 11), no flag sets bit 8.
- R9: Bit 8 holds until a clear command is sampled while no qualifying fault is present. When a qualifying fault and a clear fall on the same edge, bit 8 is set.
- R10: halt_o equals bit 8. The timer counts only in charge or discharge mode while bit 8 is clear, and otherwise it holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 idle, 01 charge, 10 discharge, 11 idle |
| start_i | input | 1 | One-cycle pulse that starts a new cycle |
| to_sel_i | input | 3 | Timeout code (0 means the timeout is off) |
| fs_clr_i | input | 1 | Clears the fail-safe flag |
| mcv_raw_i | input | 1 | Asynchronous over-voltage comparator output |
| edv_raw_i | input | 1 | Asynchronous end-of-discharge comparator output |
| htf_raw_i | input | 1 | Asynchronous hot-thermistor comparator output |
| ltf_raw_i | input | 1 | Asynchronous cold-thermistor comparator output |
| status_o | output | 9 | Status word: bit 8 fail-safe, bit 7 timeout, bits 6..3 flags, bits 2..0 zero |
| halt_o | output | 1 | Stops the active cycle |

## Verification
Two functions can meet on the same edge: setting the fail-safe latch from a fault and clearing it from the command. The bench raises the hot flag and drives the clear command on exactly the edge where the synchronized flag first qualifies. Bit 8 must then read 1. The bench drives the clear again while the fault is still held, and bit 8 must still read 1. Only once the flag has left the synchronizer may a clear drop bit 8. The timeout sweep has a similar meeting point. The timer reaches its limit and bit 7 rises with bit 8 still clear, so the bench checks that the fail-safe follows exactly one edge later.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_CHARGE = 2'b01,
    MODE_DISCH  = 2'b10,
    MODE_IDLE2  = 2'b11
  } mode_e;

  localparam int NFLAG   = 4;
  localparam int ST_W    = 9;
  localparam int B_MCV   = 3;
  localparam int B_EDV   = 4;
  localparam int B_HOT   = 5;
  localparam int B_COLD  = 6;
  localparam int B_TOUT  = 7;
  localparam int B_FS    = 8;

  // tick limit for a timeout code; code zero turns the timeout off
  function automatic int unsigned tick_limit(input logic [2:0] code,
                                             input int unsigned base);
    if (code == 3'd0) return 0;
    return base << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/bfs_cycle_timer.sv
module bfs_cycle_timer #(
  parameter int unsigned PRESCALE   = 1000,
  parameter int unsigned BASE_TICKS = 64,
  localparam int CNT_W = $clog2((BASE_TICKS << 6) + 1),
  localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [2:0] to_sel_i,
  output logic       tout_o
);
  import bfs_pkg::*;

  logic [CNT_W-1:0] lim_tab [8];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             tout_q;
  logic             tick;

  for (genvar g = 0; g < 8; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(tick_limit(3'(g), BASE_TICKS));
  end
  assign lim = lim_tab[to_sel_i];

  if (PRESCALE <= 1) begin : g_nops
    assign tick = run_i;
  end else begin : g_ps
    logic [PS_W-1:0] ps_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ps_q <= '0;
      else if (start_i)  ps_q <= '0;
      else if (run_i)    ps_q <= (ps_q == PS_W'(PRESCALE - 1)) ? '0 : ps_q + 1'b1;
    end
    assign tick = run_i && (ps_q == PS_W'(PRESCALE - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
    end else if (tick && (lim != '0) && !tout_q) begin
      if (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim}) begin
        cnt_q  <= lim;
        tout_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign tout_o = tout_q;

  // R4: a start empties the timer
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0) && !tout_q);
  // R5: timeout stays until the next start
  a_r5_tout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tout_q && !start_i |=> tout_q);
  // R10: no counting while stopped
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i && !start_i |=> $stable(cnt_q));
endmodule

// File: rtl/bfs_fs_latch.sv
module bfs_fs_latch (
  input  logic             clk,
  input  logic             rst_n,
  input  bfs_pkg::mode_e   mode_i,
  input  logic             mcv_i,
  input  logic             edv_i,
  input  logic             hot_i,
  input  logic             cold_i,
  input  logic             tout_i,
  input  logic             clr_i,
  output logic             fs_o
);
  import bfs_pkg::*;

  logic common, qualify, fs_q;

  assign common = hot_i | cold_i | tout_i;

  always_comb begin
    unique case (mode_i)
      MODE_CHARGE: qualify = common | mcv_i;
      MODE_DISCH:  qualify = common | edv_i;
      default:     qualify = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fs_q <= 1'b0;
    else if (qualify) fs_q <= 1'b1;
    else if (clr_i)   fs_q <= 1'b0;
  end

  assign fs_o = fs_q;

  // R9: set beats clear on the same edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |=> fs_q);
  // R9: held until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q && !clr_i |=> fs_q);
  // R8: idle never sets the flag
  a_r8_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_CHARGE) && (mode_i != MODE_DISCH) && !fs_q |=> !fs_q);
endmodule

// File: rtl/bat_failsafe_sup.sv
module bat_failsafe_sup #(
  parameter int unsigned PRESCALE   = 1000,
  parameter int unsigned BASE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       start_i,
  input  logic [2:0] to_sel_i,
  input  logic       fs_clr_i,
  input  logic       mcv_raw_i,
  input  logic       edv_raw_i,
  input  logic       htf_raw_i,
  input  logic       ltf_raw_i,
  output logic [8:0] status_o,
  output logic       halt_o
);
  import bfs_pkg::*;

  mode_e            mode;
  logic [NFLAG-1:0] raw, flg;
  logic             tout, fs, run;

  assign mode = mode_e'(mode_i);
  assign raw  = {ltf_raw_i, htf_raw_i, edv_raw_i, mcv_raw_i};

  bfs_sync #(.W(NFLAG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(flg)
  );

  assign run = ((mode == MODE_CHARGE) || (mode == MODE_DISCH)) && !fs;

  bfs_cycle_timer #(.PRESCALE(PRESCALE), .BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run),
    .to_sel_i(to_sel_i), .tout_o(tout)
  );

  bfs_fs_latch u_fs (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .mcv_i(flg[0]), .edv_i(flg[1]), .hot_i(flg[2]), .cold_i(flg[3]),
    .tout_i(tout), .clr_i(fs_clr_i), .fs_o(fs)
  );

  always_comb begin
    status_o         = '0;
    status_o[B_MCV]  = flg[0];
    status_o[B_EDV]  = flg[1];
    status_o[B_HOT]  = flg[2];
    status_o[B_COLD] = flg[3];
    status_o[B_TOUT] = tout;
    status_o[B_FS]   = fs;
  end

  assign halt_o = fs;

  // R6: a charge-mode timeout trips the fail-safe on the next edge
  a_r6_tout_trips: assert property (@(posedge clk) disable iff (!rst_n)
    tout && (mode == MODE_CHARGE) |=> status_o[B_FS]);
endmodule

// File: tb/bat_failsafe_sup_tb.sv
module bat_failsafe_sup_tb;
  localparam int P = 4;
  localparam int B = 2;

  logic       clk = 0, rst_n = 0, start = 0, fs_clr = 0;
  logic [1:0] mode = 0;
  logic [2:0] to_sel = 0;
  logic [3:0] raw = 0;
  logic [8:0] status;
  logic       halt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bat_failsafe_sup #(.PRESCALE(P), .BASE_TICKS(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_i(start), .to_sel_i(to_sel),
    .fs_clr_i(fs_clr), .mcv_raw_i(raw[0]), .edv_raw_i(raw[1]),
    .htf_raw_i(raw[2]), .ltf_raw_i(raw[3]), .status_o(status), .halt_o(halt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; step(1); start = 0;
  endtask

  task automatic reset_cycle();
    mode = 2'b00; pulse_start();
    fs_clr = 1; step(1); fs_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(3);
    check("R1 reset status", status, 0);
    check("R10 reset halt", halt, 0);
    rst_n = 1;
    step(1);

    // R1, R8: flag latency and idle immunity, both idle codes
    for (int m = 0; m < 4; m += 3) begin
      for (int f = 0; f < 4; f++) begin
        reset_cycle(); mode = 2'(m);
        raw[f] = 1; step(1);
        check("R1 not yet visible", status[3+f], 0);
        step(1);
        check("R1 flag visible", status[3+f], 1);
        check("R1 low bits zero", status[2:0], 0);
        step(2);
        check("R8 idle no fail-safe", status[8], 0);
        raw[f] = 0; step(2);
        check("R1 flag cleared", status[3+f], 0);
      end
    end

    // R6, R7: mode masking
    for (int m = 1; m < 3; m++) begin
      for (int f = 0; f < 4; f++) begin
        int exp;
        exp = (f >= 2) || (m == 1 && f == 0) || (m == 2 && f == 1);
        reset_cycle(); to_sel = 0; mode = 2'(m); pulse_start();
        raw[f] = 1; step(2);
        check("R6/R7 before set", status[8], 0);
        step(1);
        check(m == 1 ? "R6 charge mask" : "R7 discharge mask", status[8], exp);
        check("R10 halt follows", halt, exp);
        raw[f] = 0; step(2);
      end
    end

    // R9: set and clear on the same edge
    reset_cycle(); to_sel = 0; mode = 2'b01; pulse_start();
    raw[2] = 1; step(2);
    fs_clr = 1; step(1); fs_clr = 0;
    check("R9 set wins over clear", status[8], 1);
    fs_clr = 1; step(1); fs_clr = 0;
    check("R9 clear ignored while fault held", status[8], 1);
    raw[2] = 0; step(2);
    check("R9 sticky without fault", status[8], 1);
    fs_clr = 1; step(1); fs_clr = 0;
    check("R9 clear", status[8], 0);

    // R2, R5, R4: timeout sweep over codes
    for (int c = 1; c < 8; c++) begin
      int got, lim;
      lim = P * (B << (c - 1));
      reset_cycle(); to_sel = 3'(c); mode = 2'b01;
      start = 1; @(posedge clk); @(negedge clk); start = 0;
      got = 0;
      while (got < 2000 && !status[7]) begin
        @(posedge clk); got++; @(negedge clk);
      end
      check("R2 timeout edge", got, lim);
      check("R6 fail-safe one edge later", status[8], 0);
      step(1);
      check("R6 timeout sets fail-safe", status[8], 1);
      step(20);
      check("R5 timeout held", status[7], 1);
      mode = 2'b00; pulse_start();
      check("R4 start clears timeout", status[7], 0);
    end

    // R10: timer holds in idle
    reset_cycle(); to_sel = 3'd1; mode = 2'b01;
    start = 1; @(posedge clk); @(negedge clk); start = 0;
    step(4); mode = 2'b00; step(50); mode = 2'b01;
    step(3);
    check("R10 paused timer not expired", status[7], 0);
    step(1);
    check("R10 paused timer expires", status[7], 1);

    // R3: code 0 never times out
    reset_cycle(); to_sel = 0; mode = 2'b10; pulse_start();
    step(700);
    check("R3 no timeout", status[7], 0);
    check("R3 no fail-safe", status[8], 0);

    finish_run();
  end
endmodule